// File: doc/BRIEF.md
# Big-Endian Byte and Word Memory Access Unit

This unit sits between an execute stage and a data memory that is one 32-bit word wide. It handles four operations: load word, store word, load byte and store byte. Each operation has a base register value and a signed 16-bit displacement. The unit adds them to form the byte address. It then drives a word-aligned request, with per-byte write enables, toward the memory.

Byte lanes are numbered big-endian. The byte that sits at the word's own address is the most significant byte of the word. On a byte load, the addressed byte is selected from the returned word, placed in the low bits of the result and sign-extended to the full width. On a byte store, the low byte of the source is copied onto every lane of the write bus, and only one lane is enabled.

A word access whose address is not a multiple of four raises a misalignment flag for that cycle. The unit then issues no memory request, so no write takes place and no load result appears. Memory read latency is one cycle, and the load result is valid in the cycle after the request.

Top module: `bemem_access_unit`

## Requirements
- R1: The effective address is base_addr plus offset sign-extended to 32 bits. In the request cycle, mem_addr carries this address with bits 1:0 forced to zero.
- R2: Operation encoding on req_op: 2'b00 word load, 2'b01 word store, 2'b10 byte load, 2'b11 byte store. A valid request that is not misaligned drives mem_req high in the same cycle. mem_we is high only for stores.
- R3: A word store enables all four lanes (mem_be = 4'b1111) and drives store_data unchanged on mem_wdata.
- R4: A byte store enables exactly one lane. Bit i of mem_be covers data bits 8i+7:8i. Address bits 1:0 = L enable bit 3-L, so lane 0 is bits 31:24. The low byte of store_data appears on all four lanes of mem_wdata.
- R5: A word load raises load_valid in the cycle after the request, and load_data then equals the full word returned on mem_rdata.
- R6: A byte load raises load_valid in the cycle after the request. load_data then holds, in bits 7:0, the byte of mem_rdata chosen by address bits 1:0 in big-endian order, with bits 31:8 copies of that byte's bit 7.
- R7: A word access with address bits 1:0 non-zero drives misaligned high in the request cycle. It keeps mem_req and mem_we low, leaves memory contents unchanged, and produces no load_valid. Byte accesses never raise misaligned.
- R8: After reset, and in any cycle with no load result, load_valid is low and load_data is zero. With req_valid low, mem_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_op | input | 2 | Operation code |
| base_addr | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| store_data | input | 32 | Source register value for stores |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_be | output | 4 | Per-lane write enables |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after mem_req |
| misaligned | output | 1 | Misaligned word access flag |
| load_valid | output | 1 | Load result valid |
| load_data | output | 32 | Load result |

## Verification
The bench builds the unit with its defaults: 32-bit address and data, and a 16-bit displacement. At these values the most negative and most positive displacements, -32768 and +32767, can be tested directly. Negative offsets are checked to land back inside a small word memory modelled in the bench. All four big-endian lanes are exercised for both byte loads and byte stores. Bytes with bit 7 set and clear are both loaded, so sign extension is covered in both directions. Misaligned word stores are checked against memory contents read back afterwards.

// File: rtl/mau_pkg.sv
package mau_pkg;
    typedef enum logic [1:0] {
        OP_LDW = 2'b00,
        OP_STW = 2'b01,
        OP_LDB = 2'b10,
        OP_STB = 2'b11
    } mau_op_e;

    localparam int BYTE_W = 8;
endpackage

// File: rtl/mau_addr_gen.sv
module mau_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] eff_addr
);
    localparam int EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] off_ext;

    always_comb begin
        off_ext  = {{EXT_W{offset[OFF_W-1]}}, offset};
        eff_addr = base_addr + off_ext;
    end
endmodule

// File: rtl/mau_store_align.sv
module mau_store_align #(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8,
    parameter int LANE_W = $clog2(LANES)
) (
    input  logic              is_byte,
    input  logic [LANE_W-1:0] lane,
    input  logic [DATA_W-1:0] src,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] wdata
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // Big-endian: address lane L drives enable bit LANES-1-L
        localparam logic [LANE_W-1:0] MY_LANE = LANE_W'(LANES - 1 - i);
        always_comb begin
            be[i]          = is_byte ? (lane == MY_LANE) : 1'b1;
            wdata[8*i +: 8] = is_byte ? src[7:0] : src[8*i +: 8];
        end
    end
endmodule

// File: rtl/mau_load_align.sv
module mau_load_align #(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8,
    parameter int LANE_W = $clog2(LANES)
) (
    input  logic              valid,
    input  logic              is_byte,
    input  logic [LANE_W-1:0] lane,
    input  logic [DATA_W-1:0] word,
    output logic [DATA_W-1:0] result
);
    logic [LANE_W-1:0] pos;
    logic [7:0]        sel_byte;

    always_comb begin
        pos      = LANE_W'(LANES - 1) - lane;
        sel_byte = word[8*pos +: 8];
        if (!valid) begin
            result = '0;
        end else if (is_byte) begin
            result = {{(DATA_W-8){sel_byte[7]}}, sel_byte};
        end else begin
            result = word;
        end
    end
endmodule

// File: rtl/bemem_access_unit.sv
module bemem_access_unit
    import mau_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [OFF_W-1:0]  offset,
    input  logic [DATA_W-1:0] store_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W/8-1:0] mem_be,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              misaligned,
    output logic              load_valid,
    output logic [DATA_W-1:0] load_data
);
    localparam int LANES  = DATA_W / 8;
    localparam int LANE_W = $clog2(LANES);

    typedef struct packed {
        logic              pend;
        logic              is_byte;
        logic [LANE_W-1:0] lane;
    } ld_state_t;

    mau_op_e           op;
    logic [ADDR_W-1:0] eff_addr;
    logic [LANE_W-1:0] lane;
    logic              is_byte;
    logic              is_store;
    ld_state_t         st_d, st_q;

    mau_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_agen (
        .base_addr (base_addr),
        .offset    (offset),
        .eff_addr  (eff_addr)
    );

    always_comb begin
        op         = mau_op_e'(req_op);
        is_byte    = (op == OP_LDB) || (op == OP_STB);
        is_store   = (op == OP_STW) || (op == OP_STB);
        lane       = eff_addr[LANE_W-1:0];
        misaligned = req_valid && !is_byte && (lane != '0);
        mem_req    = req_valid && !misaligned;
        mem_we     = mem_req && is_store;
        mem_addr   = {eff_addr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
    end

    mau_store_align #(.DATA_W(DATA_W)) u_st (
        .is_byte (is_byte),
        .lane    (lane),
        .src     (store_data),
        .be      (mem_be),
        .wdata   (mem_wdata)
    );

    always_comb begin
        st_d         = st_q;
        st_d.pend    = mem_req && !is_store;
        if (mem_req && !is_store) begin
            st_d.is_byte = is_byte;
            st_d.lane    = lane;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign load_valid = st_q.pend;

    mau_load_align #(.DATA_W(DATA_W)) u_ld (
        .valid   (st_q.pend),
        .is_byte (st_q.is_byte),
        .lane    (st_q.lane),
        .word    (mem_rdata),
        .result  (load_data)
    );
endmodule

// File: rtl/bemem_access_chk.sv
module bemem_access_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_op,
    input logic              mem_req,
    input logic              mem_we,
    input logic [DATA_W/8-1:0] mem_be,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              misaligned,
    input logic              load_valid,
    input logic [DATA_W-1:0] load_data
);
    a_r1_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    a_r2_we_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_req && req_op[0]));

    a_r3_word_store_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !req_op[1]) |-> (mem_be == '1));

    a_r4_byte_store_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && req_op[1]) |-> ($countones(mem_be) == 1));

    a_r5_load_result_next: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !req_op[0]) |=> load_valid);

    a_r7_misaligned_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        misaligned |-> (!mem_req && !mem_we && !req_op[1]));

    a_r7_no_load_after_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || misaligned || req_op[0]) |=> !load_valid);

    a_r8_idle_load_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !load_valid |-> (load_data == '0));
endmodule

bind bemem_access_unit bemem_access_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_be     (mem_be),
    .mem_addr   (mem_addr),
    .misaligned (misaligned),
    .load_valid (load_valid),
    .load_data  (load_data)
);

// File: tb/bemem_access_unit_bench.sv
module bemem_access_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic [31:0] base_addr = '0;
    logic [15:0] offset = '0;
    logic [31:0] store_data = '0;
    logic        mem_req, mem_we, misaligned, load_valid;
    logic [3:0]  mem_be;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, load_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] mem [16];

    always #2 clk = ~clk;

    bemem_access_unit u_bemem_access_unit (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_op (req_op),
        .base_addr (base_addr), .offset (offset), .store_data (store_data),
        .mem_req (mem_req), .mem_we (mem_we), .mem_be (mem_be),
        .mem_addr (mem_addr), .mem_wdata (mem_wdata), .mem_rdata (mem_rdata),
        .misaligned (misaligned), .load_valid (load_valid), .load_data (load_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mem[i] <= '0;
            mem_rdata <= '0;
        end else if (mem_req) begin
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr[5:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
            end else begin
                mem_rdata <= mem[mem_addr[5:2]];
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] op, input logic [31:0] b,
                         input logic [15:0] o, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; base_addr = b; offset = o; store_data = d;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        #1;
    endtask

    task automatic t_store(input logic [1:0] op, input logic [31:0] b, input logic [15:0] o,
                           input logic [31:0] d, input logic [3:0] exp_be,
                           input logic [31:0] exp_wd, input string tag);
        drive(op, b, o, d);
        check(mem_req && mem_we && !misaligned, {tag, " strobes"}, {29'd0, misaligned, mem_we, mem_req}, 32'd3);
        check(mem_be == exp_be, {tag, " be"}, {28'd0, mem_be}, {28'd0, exp_be});
        check(mem_wdata == exp_wd, {tag, " wdata"}, mem_wdata, exp_wd);
        idle();
    endtask

    task automatic t_load(input logic [1:0] op, input logic [31:0] b, input logic [15:0] o,
                          input logic [31:0] exp_addr, input logic [31:0] exp, input string tag);
        drive(op, b, o, 32'h0);
        check(mem_req && !mem_we && mem_addr == exp_addr, {tag, " request"}, mem_addr, exp_addr);
        idle();
        check(load_valid == 1'b1, {tag, " valid"}, {31'd0, load_valid}, 32'd1);
        check(load_data == exp, {tag, " data"}, load_data, exp);
    endtask

    task automatic t_reset();
        #1;
        check(!load_valid && load_data == 0, "R8 reset load", load_data, 32'd0);
        check(!mem_req, "R8 reset req", {31'd0, mem_req}, 32'd0);
    endtask

    task automatic t_word();
        t_store(2'b01, 32'h1000, 16'h0000, 32'h8A3C5E71, 4'b1111, 32'h8A3C5E71, "R3 word store");
        t_load(2'b00, 32'h1000, 16'h0000, 32'h1000, 32'h8A3C5E71, "R5 word load");
    endtask

    task automatic t_byte_load();
        t_load(2'b10, 32'h1000, 16'h0000, 32'h1000, 32'hFFFFFF8A, "R6 lane0 negative");
        t_load(2'b10, 32'h1000, 16'h0001, 32'h1000, 32'h0000003C, "R6 lane1");
        t_load(2'b10, 32'h1000, 16'h0002, 32'h1000, 32'h0000005E, "R6 lane2");
        t_load(2'b10, 32'h1000, 16'h0003, 32'h1000, 32'h00000071, "R6 lane3");
    endtask

    task automatic t_byte_store();
        t_store(2'b01, 32'h1010, 16'h0000, 32'h00000000, 4'b1111, 32'h0, "R3 clear word");
        t_store(2'b11, 32'h1010, 16'h0001, 32'hFFFFFF9B, 4'b0100, 32'h9B9B9B9B, "R4 lane1 store");
        t_store(2'b11, 32'h1010, 16'h0003, 32'h12345607, 4'b0001, 32'h07070707, "R4 lane3 store");
        t_store(2'b11, 32'h1014, 16'h0000, 32'h000000C4, 4'b1000, 32'hC4C4C4C4, "R4 lane0 store");
        t_load(2'b00, 32'h1010, 16'h0000, 32'h1010, 32'h009B0007, "R4 merged word");
        t_load(2'b00, 32'h1014, 16'h0000, 32'h1014, 32'hC4000000, "R4 lane0 word");
    endtask

    task automatic t_offsets();
        t_load(2'b00, 32'h1008, 16'hFFF8, 32'h1000, 32'h8A3C5E71, "R1 negative offset");
        t_load(2'b10, 32'h9000, 16'h8000, 32'h1000, 32'hFFFFFF8A, "R1 min offset");
        drive(2'b10, 32'h00000FFD, 16'h7FFF, 32'h0);
        check(mem_addr == 32'h00008FFC && !misaligned, "R1 max offset addr", mem_addr, 32'h8FFC);
        idle();
    endtask

    task automatic t_misaligned();
        drive(2'b01, 32'h1000, 16'h0002, 32'hDEADBEEF);
        check(misaligned && !mem_req && !mem_we, "R7 misaligned store",
              {29'd0, misaligned, mem_we, mem_req}, 32'd4);
        idle();
        t_load(2'b00, 32'h1000, 16'h0000, 32'h1000, 32'h8A3C5E71, "R7 memory unchanged");
        drive(2'b00, 32'h1000, 16'h0001, 32'h0);
        check(misaligned && !mem_req, "R7 misaligned load", {30'd0, misaligned, mem_req}, 32'd2);
        idle();
        check(!load_valid && load_data == 0, "R7 no load result", {31'd0, load_valid}, 32'd0);
        drive(2'b11, 32'h1000, 16'h0001, 32'h0);
        check(!misaligned && mem_req, "R7 byte never misaligned", {31'd0, misaligned}, 32'd0);
        idle();
    endtask

    task automatic t_idle();
        idle();
        check(!mem_req && !mem_we, "R2 idle no request", {30'd0, mem_we, mem_req}, 32'd0);
        idle();
        check(!load_valid && load_data == 0, "R8 idle result", load_data, 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_word();
        t_byte_load();
        t_byte_store();
        t_offsets();
        t_misaligned();
        t_idle();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule